// File: doc/BRIEF.md
# Slot-Based Interrupt Router

This block takes interrupt events from devices on a PCI bus and decides which internal interrupt line each one belongs to. The line depends on the device's slot number and on which of its four interrupt pins (INTA to INTD, index 0 to 3) fired. The add-in slots rotate their pins across neighbouring lines so that devices share lines evenly. The mapped line number is presented combinationally. The block also drives one registered interrupt output towards the CPU.

Each internal line numbered from 32 upward has one bit in a 32-bit edge register and one bit in a 32-bit polarity register. The bit index is the line number minus 32. When a line's edge bit is set, an event on it produces a one-cycle pulse on the CPU output. When the edge bit is clear, the CPU output takes the value of the line's polarity bit and keeps it until the next event. The event interface is a single-cycle strobe that is always accepted, so the block never applies back-pressure. Both configuration registers are read directly every cycle.

Top module: `irq_slot_router`

## Requirements
- R1: Slot 5 maps pin n (0..3) to line 32 + n.
- R2: Slot 6 maps every pin to line 36, and slot 7 maps every pin to line 37.
- R3: Slots 8 to 12 map pin n to line (slot - 8 + n) + 38, so slot 12 pin 3 gives line 45.
- R4: Any other slot (0..4, 13..31) returns the pin index itself (0..3) as the line number.
- R5: `line_num` is combinational from `evt_slot` and `evt_pin`, valid in the same cycle, whether or not `evt_valid` is high.
- R6: An event on a line L >= 32 with `edge_cfg[L-32]` = 1 drives `cpu_irq` high for exactly one cycle, starting the cycle after the event. It then returns low unless another event arrives.
- R7: An event on a line L >= 32 with `edge_cfg[L-32]` = 0 sets `cpu_irq` to `pol_cfg[L-32]` from the next cycle. The value holds until a later event changes it.
- R8: Only the configuration bit at index L-32 of the event's own line affects the result. The other bits of `edge_cfg` and `pol_cfg` have no effect.
- R9: `evt_level` has no effect on `cpu_irq`.
- R10: An event whose line is below 32 (a pass-through slot) leaves `cpu_irq` unchanged, except that a pulse in progress still ends. Cycles without an event behave the same way.
- R11: While `rst_n` is low and in the first cycle after reset, `cpu_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle interrupt event strobe, always accepted |
| evt_slot | input | 5 | Slot number of the requesting device |
| evt_pin | input | 2 | Interrupt pin index, 0 = INTA .. 3 = INTD |
| evt_level | input | 1 | Reported pin level (ignored by the output logic) |
| edge_cfg | input | 32 | Per-line pulse select, bit index = line - 32 |
| pol_cfg | input | 32 | Per-line level value when not pulsed, bit index = line - 32 |
| line_num | output | 6 | Mapped internal line number |
| cpu_irq | output | 1 | Registered interrupt output to the CPU |

## Verification
The mapping is tested with every pin on the on-board slots 5, 6 and 7 and on every add-in slot up to the slot 12 / pin 3 corner. Pass-through slots on both sides of the mapped range are included, which separates a fixed line from a rotated one and from a pin passed straight through. The output logic is tested with pulse events followed by idle cycles, with back-to-back pulses, with level events of both polarities, and with level events followed by unmapped events. Together these separate a one-cycle pulse from a held level and a hold from a clear. Random slots, pins, levels and register values from a fixed seed check that only the event line's own bits matter and that the reported pin level never does.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SLOT_W       = 5;
  localparam int PIN_W        = 2;
  localparam int LINE_W       = 6;
  localparam int CFG_W        = 32;
  localparam int LINE_BASE    = 32;
  localparam int IDX_W        = $clog2(CFG_W);

  // board slot assignment
  localparam int SLOT_SOUTH   = 5;   // four pins onto four lines
  localparam int SLOT_VIDEO   = 6;   // all pins onto one line
  localparam int SLOT_NET     = 7;   // all pins onto one line
  localparam int SLOT_ADD_LO  = 8;   // first rotating add-in slot
  localparam int SLOT_ADD_HI  = 12;  // last rotating add-in slot

  localparam int LINE_VIDEO   = LINE_BASE + 4;
  localparam int LINE_NET     = LINE_BASE + 5;
  localparam int LINE_ADD0    = LINE_BASE + 6;
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_route_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  output logic [LINE_W-1:0] line
);
  localparam logic [LINE_W-1:0] ADD_OFS = LINE_W'(LINE_ADD0 - SLOT_ADD_LO);

  logic [LINE_W-1:0] slot_w, pin_w;
  assign slot_w = LINE_W'(slot);
  assign pin_w  = LINE_W'(pin);

  always_comb begin
    if (slot == SLOT_W'(SLOT_SOUTH))
      line = LINE_W'(LINE_BASE) + pin_w;
    else if (slot == SLOT_W'(SLOT_VIDEO))
      line = LINE_W'(LINE_VIDEO);
    else if (slot == SLOT_W'(SLOT_NET))
      line = LINE_W'(LINE_NET);
    else if (slot >= SLOT_W'(SLOT_ADD_LO) && slot <= SLOT_W'(SLOT_ADD_HI))
      line = slot_w + pin_w + ADD_OFS;
    else
      line = pin_w;
  end
endmodule

// File: rtl/irq_cfg_sel.sv
module irq_cfg_sel
  import irq_route_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  input  logic [CFG_W-1:0]  edge_cfg,
  input  logic [CFG_W-1:0]  pol_cfg,
  output logic              mapped,
  output logic              edge_bit,
  output logic              pol_bit
);
  logic [LINE_W-1:0] ofs;
  logic [IDX_W-1:0]  idx;

  assign ofs    = line - LINE_W'(LINE_BASE);
  assign idx    = ofs[IDX_W-1:0];
  assign mapped = (line >= LINE_W'(LINE_BASE)) && (ofs < LINE_W'(CFG_W));
  assign edge_bit = edge_cfg[idx];
  assign pol_bit  = pol_cfg[idx];
endmodule

// File: rtl/irq_out_drv.sv
module irq_out_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic edge_bit,
  input  logic pol_bit,
  output logic irq
);
  logic irq_q, pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (fire) begin
      irq_q   <= edge_bit ? 1'b1 : pol_bit;
      pulse_q <= edge_bit;
    end else if (pulse_q) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [4:0]        evt_slot,
  input  logic [1:0]        evt_pin,
  input  logic              evt_level,
  input  logic [31:0]       edge_cfg,
  input  logic [31:0]       pol_cfg,
  output logic [5:0]        line_num,
  output logic              cpu_irq
);
  logic mapped, edge_bit, pol_bit, fire;
  logic unused_level;

  assign unused_level = evt_level;

  irq_slot_map u_map (
    .slot (evt_slot),
    .pin  (evt_pin),
    .line (line_num)
  );

  irq_cfg_sel u_sel (
    .line     (line_num),
    .edge_cfg (edge_cfg),
    .pol_cfg  (pol_cfg),
    .mapped   (mapped),
    .edge_bit (edge_bit),
    .pol_bit  (pol_bit)
  );

  assign fire = evt_valid && mapped;

  irq_out_drv u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .edge_bit (edge_bit),
    .pol_bit  (pol_bit),
    .irq      (cpu_irq)
  );
endmodule

// File: rtl/irq_slot_router_chk.sv
module irq_slot_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_valid,
  input logic [4:0]  evt_slot,
  input logic [1:0]  evt_pin,
  input logic [31:0] edge_cfg,
  input logic [31:0] pol_cfg,
  input logic [5:0]  line_num,
  input logic        cpu_irq
);
  logic       in_rng, ev_edge, ev_lvl, ev_pol, pend;
  logic [5:0] ofs;

  assign ofs     = line_num - 6'd32;
  assign in_rng  = (line_num >= 6'd32);
  assign ev_edge = evt_valid && in_rng && edge_cfg[ofs[4:0]];
  assign ev_lvl  = evt_valid && in_rng && !edge_cfg[ofs[4:0]];
  assign ev_pol  = pol_cfg[ofs[4:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= ev_edge;
  end

  // R6
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_edge |=> cpu_irq);

  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(evt_valid && in_rng)) |=> !cpu_irq);

  // R7
  level_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lvl |=> (cpu_irq == $past(ev_pol)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !(evt_valid && in_rng)) |=> $stable(cpu_irq));

  // R2
  fixed_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_slot == 5'd6) |-> (line_num == 6'd36));

  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_slot < 5'd5 || evt_slot > 5'd12) |-> (line_num == {4'd0, evt_pin}));
endmodule

bind irq_slot_router irq_slot_router_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_slot  (evt_slot),
  .evt_pin   (evt_pin),
  .edge_cfg  (edge_cfg),
  .pol_cfg   (pol_cfg),
  .line_num  (line_num),
  .cpu_irq   (cpu_irq)
);

// File: tb/irq_slot_router_bench.sv
module irq_slot_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_slot = '0;
  logic [1:0]  evt_pin = '0;
  logic        evt_level = 1'b0;
  logic [31:0] edge_cfg = '0;
  logic [31:0] pol_cfg = '0;
  logic [5:0]  line_num;
  logic        cpu_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic exp_irq = 1'b0, exp_pulse = 1'b0;

  always #10 clk = ~clk;

  irq_slot_router u_irq_slot_router (.*);

  function automatic int ref_line(int s, int p);
    if (s == 5) return 32 + p;
    if (s == 6) return 36;
    if (s == 7) return 37;
    if (s >= 8 && s <= 12) return s - 8 + p + 38;
    return p;
  endfunction

  function automatic string map_tag(int s);
    if (s == 5) return "R1";
    if (s == 6 || s == 7) return "R2";
    if (s >= 8 && s <= 12) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge after checking cpu_irq
  task automatic step(bit v, int s, int p, bit lvl, string otag);
    int l;
    evt_valid = v; evt_slot = 5'(s); evt_pin = 2'(p); evt_level = lvl;
    #1;
    l = ref_line(s, p);
    check({map_tag(s), "/R5 line"}, int'(line_num), l);
    if (v && l >= 32) begin
      if (edge_cfg[l-32]) begin exp_irq = 1'b1; exp_pulse = 1'b1; end
      else begin exp_irq = pol_cfg[l-32]; exp_pulse = 1'b0; end
    end else if (exp_pulse) begin
      exp_irq = 1'b0; exp_pulse = 1'b0;
    end
    @(negedge clk);
    evt_valid = 1'b0;
    check({otag, " cpu_irq"}, int'(cpu_irq), int'(exp_irq));
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11 reset cpu_irq", int'(cpu_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 post-reset cpu_irq", int'(cpu_irq), 0);

    // mapping sweep, no events (R1..R5)
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) step(0, s, p, 0, "R10 idle");

    // R6 pulse then idle, then back-to-back pulses
    edge_cfg = 32'h0000_0001 << 13;  // line 45
    pol_cfg  = '0;
    step(1, 12, 3, 0, "R6 pulse");
    step(0, 0, 0, 0, "R6 pulse end");
    step(0, 0, 0, 0, "R6 stays low");
    step(1, 12, 3, 1, "R6 b2b first");
    step(1, 12, 3, 0, "R6 b2b second");
    step(0, 0, 0, 0, "R6 b2b end");

    // R7 level both polarities, R8 neighbour bits ignored
    edge_cfg = 32'hFFFF_FFFE;        // line 32 level, others pulse
    pol_cfg  = 32'h0000_0001;
    step(1, 5, 0, 0, "R7 level high");
    step(0, 0, 0, 0, "R7 hold high");
    pol_cfg  = 32'hFFFF_FFFE;        // only own bit cleared
    step(1, 5, 0, 1, "R8 own bit low");
    step(0, 0, 0, 0, "R7 hold low");

    // R10 unmapped event after high level holds; R9 level ignored
    pol_cfg = 32'h0000_0001;
    step(1, 5, 0, 0, "R9 level input 0");
    step(1, 3, 2, 1, "R10 unmapped holds");
    step(1, 20, 1, 0, "R10 unmapped holds");
    // unmapped event ends a pulse
    step(1, 6, 2, 0, "R6 pulse line36");
    step(1, 0, 3, 1, "R10 pulse ends on unmapped");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int s;
      if (i % 50 == 0) begin edge_cfg = $urandom; pol_cfg = $urandom; end
      s = ($urandom % 4 == 0) ? int'($urandom % 32) : 5 + int'($urandom % 8);
      step(($urandom % 3) != 0, s, int'($urandom % 4), 1'($urandom), "R6/R7/R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule